// File: doc/BRIEF.md
# CAN Transmit Payload Byte Sequencer

This block stores the data field of one pending CAN transmit frame and feeds it, one byte at a time, to a downstream bit-stream serializer. Software loads the payload through a 32-bit write port with per-byte enables. The port addresses two data words: a low word holding payload bytes 1 to 4 and a high word holding bytes 5 to 8. A transmit request samples the frame's remote-request flag and its 4-bit length code. The block then works out how many payload bytes the frame carries and sends them in increasing index order over a valid/ready handshake.

While a frame is being sent, the buffer-free flag is low. During that time software writes and further transmit requests are ignored, so the payload cannot change in the middle of a frame. A single-cycle frame-done pulse marks the end of each frame, including frames that carry no data. Arbitration field, stuffing, CRC and bus timing belong to the serializer and are not handled here.

Top module: `can_tx_payload_seq`

## Requirements
- R1: After reset, buf_free is 1, out_valid and frame_done are 0, and both data words hold zero.
- R2: The low word (wr_sel=0) carries payload byte 1 in bits 7:0, byte 2 in 15:8, byte 3 in 23:16 and byte 4 in 31:24, and these are emitted as out_idx 0 to 3.
- R3: The high word (wr_sel=1) carries bytes 5 to 8 in the same low-to-high lane order, and these are emitted as out_idx 4 to 7.
- R4: A write updates only the byte lanes of the selected word whose wr_be bit is 1; wr_be[k] guards bits 8k+7:8k.
- R5: A write issued while buf_free is 0 leaves both data words unchanged.
- R6: With fi_rtr=0, the number of bytes emitted equals the length code, and codes 9 to 15 send eight bytes.
- R7: With fi_rtr=1, no byte is emitted whatever the length code.
- R8: An accepted request with at least one byte to send drives buf_free to 0 and out_valid to 1 on the next cycle. buf_free returns to 1 in the cycle after the last byte's handshake.
- R9: An accepted request with zero bytes to send keeps buf_free at 1 and raises frame_done on the next cycle.
- R10: Bytes are emitted in increasing index order. While out_valid is 1 and out_ready is 0, out_data and out_idx hold steady.
- R11: frame_done is a one-cycle pulse with out_valid low, in the cycle after the final handshake.
- R12: tx_req is ignored while buf_free is 0, and fi_rtr/fi_dlc are sampled only when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Data-word write strobe |
| wr_sel | input | 1 | Word select: 0 = bytes 1-4, 1 = bytes 5-8 |
| wr_be | input | 4 | Byte-lane enables for the write |
| wr_data | input | 32 | Write data |
| tx_req | input | 1 | Transmit request pulse |
| fi_rtr | input | 1 | Remote-request flag of the frame |
| fi_dlc | input | 4 | Data length code of the frame |
| buf_free | output | 1 | Buffer free; writes and requests accepted |
| out_valid | output | 1 | A payload byte is offered |
| out_ready | input | 1 | Serializer takes the offered byte |
| out_data | output | 8 | Offered payload byte |
| out_idx | output | 3 | Zero-based index of the offered byte |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The main function is swept over all sixteen length codes under both values of the remote-request flag. Every frame uses distinct byte values, so a swapped lane, a wrong word or a reordered byte each shows up as a specific mismatch. The ready input follows a stall pattern that changes from frame to frame, which separates hold-while-stalled errors from sequencing errors. Partial byte-enable writes check lane merging. Writes and requests injected in mid-frame, followed by a later frame that reads the stored data back out, show whether the busy-time lockout holds.

// File: rtl/can_txp_pkg.sv
package can_txp_pkg;

   localparam int unsigned TXP_BYTE_W     = 8;
   localparam int unsigned TXP_WORD_BYTES = 4;
   localparam int unsigned TXP_NUM_WORDS  = 2;
   localparam int unsigned TXP_DLC_W      = 4;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_SEND = 1'b1
   } seq_state_e;

   function automatic int unsigned txp_idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/txp_word_bank.sv
module txp_word_bank #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int NUM_WORDS  = 2,
   parameter int SEL_W      = 1,
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int PAY_W     = WORD_W * NUM_WORDS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_allow,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [WORD_BYTES-1:0] wr_be,
   input  logic [WORD_W-1:0]     wr_data,
   output logic [PAY_W-1:0]      payload
);

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      assign hit = wr_en && wr_allow && (wr_sel == SEL_W'(w));

      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
         logic [BYTE_W-1:0] lane_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (hit && wr_be[b]) begin
               lane_q <= wr_data[b*BYTE_W +: BYTE_W];
            end
         end

         assign payload[(w*WORD_BYTES + b)*BYTE_W +: BYTE_W] = lane_q;
      end
   end

endmodule

// File: rtl/txp_len_calc.sv
module txp_len_calc #(
   parameter int DLC_W     = 4,
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = 4
) (
   input  logic             rtr,
   input  logic [DLC_W-1:0] dlc,
   output logic [CNT_W-1:0] count
);

   localparam int DLC_MAX = (1 << DLC_W) - 1;

   logic [CNT_W-1:0] raw;

   if (DLC_MAX > MAX_BYTES) begin : g_clamp
      assign raw = (dlc > DLC_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : CNT_W'(dlc);
   end else begin : g_pass
      assign raw = CNT_W'(dlc);
   end

   assign count = rtr ? '0 : raw;

endmodule

// File: rtl/txp_byte_seq.sv
module txp_byte_seq
   import can_txp_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 8,
   parameter int CNT_W     = 4,
   parameter int IDX_W     = 3,
   localparam int PAY_W    = BYTE_W * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_req,
   input  logic [CNT_W-1:0]  count_in,
   input  logic [PAY_W-1:0]  payload,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic [IDX_W-1:0]  out_idx,
   output logic              frame_done,
   output logic              busy
);

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_q;
   logic             done_q;
   logic             last_hit;

   logic [BYTE_W-1:0] lane [MAX_BYTES];

   for (genvar i = 0; i < MAX_BYTES; i++) begin : g_unpack
      assign lane[i] = payload[i*BYTE_W +: BYTE_W];
   end

   assign last_hit = (idx_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_IDLE: begin
               if (tx_req) begin
                  if (count_in == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= SEQ_SEND;
                     idx_q   <= '0;
                     last_q  <= IDX_W'(count_in - CNT_W'(1));
                  end
               end
            end
            SEQ_SEND: begin
               if (out_ready) begin
                  if (last_hit) begin
                     state_q <= SEQ_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy       = (state_q == SEQ_SEND);
   assign out_valid  = busy;
   assign out_idx    = idx_q;
   assign out_data   = lane[idx_q];
   assign frame_done = done_q;

endmodule

// File: rtl/can_tx_payload_seq.sv
module can_tx_payload_seq
   import can_txp_pkg::*;
#(
   parameter int BYTE_W     = TXP_BYTE_W,
   parameter int WORD_BYTES = TXP_WORD_BYTES,
   parameter int NUM_WORDS  = TXP_NUM_WORDS,
   parameter int DLC_W      = TXP_DLC_W,
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int MAX_BYTES = WORD_BYTES * NUM_WORDS,
   localparam int PAY_W     = WORD_W * NUM_WORDS,
   localparam int SEL_W     = txp_idx_w(NUM_WORDS),
   localparam int IDX_W     = txp_idx_w(MAX_BYTES),
   localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [SEL_W-1:0]      wr_sel,
   input  logic [WORD_BYTES-1:0] wr_be,
   input  logic [WORD_W-1:0]     wr_data,
   input  logic                  tx_req,
   input  logic                  fi_rtr,
   input  logic [DLC_W-1:0]      fi_dlc,
   output logic                  buf_free,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [BYTE_W-1:0]     out_data,
   output logic [IDX_W-1:0]      out_idx,
   output logic                  frame_done
);

   if (BYTE_W < 1) begin : g_bad_byte
      $error("BYTE_W must be at least 1");
   end
   if (WORD_BYTES < 1 || NUM_WORDS < 1) begin : g_bad_geom
      $error("WORD_BYTES and NUM_WORDS must be at least 1");
   end
   if (DLC_W < 1 || DLC_W > 8) begin : g_bad_dlc
      $error("DLC_W must lie in 1..8");
   end

   logic [PAY_W-1:0] pay_q;
   logic [CNT_W-1:0] frame_cnt;
   logic             busy;

   txp_word_bank #(
      .BYTE_W     (BYTE_W),
      .WORD_BYTES (WORD_BYTES),
      .NUM_WORDS  (NUM_WORDS),
      .SEL_W      (SEL_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_allow (!busy),
      .wr_sel   (wr_sel),
      .wr_be    (wr_be),
      .wr_data  (wr_data),
      .payload  (pay_q)
   );

   txp_len_calc #(
      .DLC_W     (DLC_W),
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W)
   ) u_len (
      .rtr   (fi_rtr),
      .dlc   (fi_dlc),
      .count (frame_cnt)
   );

   txp_byte_seq #(
      .BYTE_W    (BYTE_W),
      .MAX_BYTES (MAX_BYTES),
      .CNT_W     (CNT_W),
      .IDX_W     (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_req     (tx_req),
      .count_in   (frame_cnt),
      .payload    (pay_q),
      .out_ready  (out_ready),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_idx    (out_idx),
      .frame_done (frame_done),
      .busy       (busy)
   );

   assign buf_free = !busy;

endmodule

// File: rtl/txp_chk.sv
module txp_chk #(
   parameter int PAY_W  = 64,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              tx_req,
   input logic              fi_rtr,
   input logic              buf_free,
   input logic              out_valid,
   input logic              out_ready,
   input logic [BYTE_W-1:0] out_data,
   input logic [IDX_W-1:0]  out_idx,
   input logic              frame_done,
   input logic [PAY_W-1:0]  pay_q
);

   // R5
   ignored_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !buf_free |=> $stable(pay_q));

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx));

   // R10
   next_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=>
         (out_valid && out_idx == IDX_W'($past(out_idx) + IDX_W'(1))) ||
         (!out_valid && frame_done));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !out_valid && buf_free);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done && !tx_req |=> !frame_done);

   // R7
   remote_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req && buf_free && fi_rtr |=> frame_done && !out_valid && buf_free);

   // R8
   busy_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !buf_free);

   // R12
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_free && !out_ready |=> !buf_free && !frame_done);

endmodule

bind can_tx_payload_seq txp_chk #(
   .PAY_W  (PAY_W),
   .BYTE_W (BYTE_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .tx_req     (tx_req),
   .fi_rtr     (fi_rtr),
   .buf_free   (buf_free),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .out_idx    (out_idx),
   .frame_done (frame_done),
   .pay_q      (pay_q)
);

// File: tb/can_tx_payload_seq_tb.sv
module can_tx_payload_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [0:0]  wr_sel = '0;
   logic [3:0]  wr_be = '0;
   logic [31:0] wr_data = '0;
   logic        tx_req = 1'b0;
   logic        fi_rtr = 1'b0;
   logic [3:0]  fi_dlc = '0;
   logic        buf_free;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic [2:0]  out_idx;
   logic        frame_done;

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 1'b0;
   logic [31:0] wa = '0;
   logic [31:0] wb = '0;

   always #10 clk = ~clk;

   can_tx_payload_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
      .wr_data(wr_data), .tx_req(tx_req), .fi_rtr(fi_rtr), .fi_dlc(fi_dlc),
      .buf_free(buf_free), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_idx(out_idx), .frame_done(frame_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old_w,
                                         input logic [31:0] new_w,
                                         input logic [3:0] be);
      logic [31:0] r = old_w;
      for (int k = 0; k < 4; k++)
         if (be[k]) r[k*8 +: 8] = new_w[k*8 +: 8];
      return r;
   endfunction

   function automatic logic [7:0] exp_byte(input int k);
      if (k < 4) return wa[k*8 +: 8];
      return wb[(k-4)*8 +: 8];
   endfunction

   // One write; the model follows only when the buffer is known to be free.
   task automatic do_write(input bit sel, input logic [3:0] be,
                           input logic [31:0] d, input bit model);
      wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (model) begin
         if (sel) wb = merge(wb, d, be);
         else     wa = merge(wa, d, be);
      end
   endtask

   task automatic run_frame(input bit rtr, input logic [3:0] dlc, input int seed,
                            input bit inject, input string xt);
      int n = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
      int k = 0;
      int cyc = 0;
      bit rdy;
      tx_req = 1'b1; fi_rtr = rtr; fi_dlc = dlc;
      @(negedge clk);
      tx_req = 1'b0; fi_rtr = ~rtr; fi_dlc = ~dlc;
      if (n == 0) begin
         chk(frame_done && buf_free && !out_valid,
             rtr ? {"R7 empty frame ", xt} : {"R9 empty frame ", xt},
             {29'd0, frame_done, buf_free, out_valid}, 32'h6);
         @(negedge clk);
         chk(!frame_done, {"R11 pulse width ", xt}, {31'd0, frame_done}, 0);
         return;
      end
      chk(!buf_free && out_valid, {"R8 busy after request ", xt},
          {30'd0, buf_free, out_valid}, 32'h1);
      while (k < n && cyc < 100) begin
         rdy = (((cyc * 7) + seed) % 3) != 0;
         if (inject && cyc == 0) begin
            rdy = 1'b0;
            wr_en = 1'b1; wr_sel = 1'b0; wr_be = 4'hF; wr_data = 32'hDEAD_BEEF;
            tx_req = 1'b1; fi_rtr = 1'b1; fi_dlc = 4'd0;
         end
         out_ready = rdy;
         chk(out_valid && out_idx == 3'(k), {"R10 index order ", xt},
             {28'd0, out_valid, out_idx}, {28'd1, 3'(k)});
         chk(out_data == exp_byte(k), {(k < 4) ? "R2 byte " : "R3 byte ", xt},
             {24'd0, out_data}, {24'd0, exp_byte(k)});
         if (rdy) k++;
         @(negedge clk);
         wr_en = 1'b0; tx_req = 1'b0; out_ready = 1'b0;
         cyc++;
      end
      chk(frame_done && buf_free && !out_valid, {"R6 R8 R11 frame end ", xt},
          {29'd0, frame_done, buf_free, out_valid}, 32'h6);
      @(negedge clk);
      chk(!frame_done && !out_valid, {"R11 R12 after end ", xt},
          {30'd0, frame_done, out_valid}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk(buf_free && !out_valid && !frame_done, "R1 reset outputs",
          {29'd0, buf_free, out_valid, frame_done}, 32'h4);
      // R1: stored words are zero
      run_frame(1'b0, 4'd8, 0, 1'b0, "R1 zero words");

      // R6 R7 R9 R2 R3: sweep of all length codes and both flag values
      for (int f = 0; f < 32; f++) begin
         bit r = f[4];
         logic [7:0] base = 8'(f * 8);
         do_write(1'b0, 4'hF, {base + 8'd4, base + 8'd3, base + 8'd2, base + 8'd1}, 1'b1);
         do_write(1'b1, 4'hF, {base + 8'h88, base + 8'h87, base + 8'h86, base + 8'h85}, 1'b1);
         run_frame(r, 4'(f), f, 1'b0, "sweep");
      end

      // R4: partial byte enables on both words
      do_write(1'b0, 4'hF, 32'h4433_2211, 1'b1);
      do_write(1'b0, 4'b0101, 32'hAABB_CCDD, 1'b1);
      do_write(1'b1, 4'hF, 32'h8877_6655, 1'b1);
      do_write(1'b1, 4'b1010, 32'h1020_3040, 1'b1);
      run_frame(1'b0, 4'd8, 5, 1'b0, "R4 lane merge");

      // R5 R12: write and request during a frame are ignored
      run_frame(1'b0, 4'd8, 2, 1'b1, "R12 request while busy");
      run_frame(1'b0, 4'd4, 1, 1'b0, "R5 data kept");

      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule